// File: doc/BRIEF.md
# Clocked Synchronous Serial Transmitter

This block sends bytes over a clocked serial link. It has two data stages. The host writes a byte into a holding register. The block then moves that byte into a shift register, which drives one data line one bit at a time, least significant bit first. A serial clock goes out on its own pin beside the data. The data line changes on the falling clock edge, so a receiver can sample it on the rising edge.

The bit clock comes from one of two sources. In internal mode a divider runs on the system clock, and each bit lasts 2×(N+1) system cycles. In external mode the shifting follows an external clock input instead. Two flags report the state of the transmitter: one says the holding register is empty, the other says transmission has ended. Two interrupt request pulses, each with its own enable, follow those two events.

The choice of the next byte is made at the rising edge of bit 7. If a byte is waiting, the next frame starts straight away with no gap. If none is waiting, the clock stops high and the data line keeps the level of the last bit. While any receive-error input is set, no frame may start.

Top module: `sync_ser_tx`

## Requirements
- R1: After reset, `empty_o`=1, `tend_o`=1, `sck_o`=1, `txd_o`=1, and both interrupt outputs are 0.
- R2: A cycle with `wr_en`=1 stores `wr_data` in the holding register and clears `empty_o` to 0.
- R3: When the transmitter is idle, `empty_o`=0 and `rx_err`=0, the byte moves to the shift register. In that same cycle `empty_o` goes to 1, `tend_o` goes to 0, and `txi_o` pulses for one cycle if `tie_en`=1.
- R4: Each frame is 8 bits, sent from bit 0 up to bit 7. `txd_o` changes only when the serial clock falls, and it is stable while the clock is high.
- R5: In internal mode (`ext_sel`=0), one bit lasts 2×(`div_n`+1) system clock cycles. The clock is low for the first half of the bit and high for the second half.
- R6: At the rising clock edge of bit 7, the block checks for a waiting byte (`empty_o`=0 and `rx_err`=0). If one is waiting, it loads that byte, and bit 0 of the new frame falls `div_n`+1 cycles after the bit-7 rise. This is the same half-bit spacing as inside a frame.
- R7: If no byte is waiting at the bit-7 check, `tend_o` goes to 1, `sck_o` stays high, and `txd_o` keeps the level of bit 7. `tei_o` pulses for one cycle if `teie_en`=1.
- R8: While any bit of `rx_err` (overrun, framing, parity) is 1, no byte is loaded, either at an idle start or at the bit-7 check. A written byte stays pending and is sent once `rx_err` returns to 0.
- R9: In external mode (`ext_sel`=1), a falling edge of `ext_sck` shifts out the next bit, and a rising edge of `ext_sck` ends that bit. `sck_o` stays high for the whole time.
- R10: When `tie_en`=0 or `teie_en`=0, the matching interrupt output never pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host write strobe for the holding register |
| wr_data | input | 8 | Byte to transmit |
| div_n | input | 8 | Divider value N; one bit lasts 2×(N+1) cycles |
| ext_sel | input | 1 | 1 selects the external bit clock |
| ext_sck | input | 1 | External bit clock, asynchronous |
| tie_en | input | 1 | Enable for the empty-buffer interrupt |
| teie_en | input | 1 | Enable for the transmit-end interrupt |
| rx_err | input | 3 | Receive errors {overrun, framing, parity}; any 1 blocks loads |
| sck_o | output | 1 | Serial clock, high when idle |
| txd_o | output | 1 | Serial data |
| empty_o | output | 1 | Holding register empty flag |
| tend_o | output | 1 | Transmission ended flag |
| txi_o | output | 1 | Empty-buffer interrupt pulse |
| tei_o | output | 1 | Transmit-end interrupt pulse |

## Verification
The bench sends one byte after another with back-to-back frames, and it measures the time from the bit-7 rise to the next bit-0 fall. A design that makes the next-byte decision too late would leave an extra idle half-bit there. The bench raises a receive error both before a start and in the middle of a frame. A design that checks the error only at an idle start would send the pending byte anyway, and one that forgets the byte would never send it. The bench uses bytes whose bit 7 is 0 to show that the line keeps the last bit rather than going back to idle high. It runs external mode with `sck_o` observed, so a design that drives the pin from the divider in that mode would be caught.

// File: rtl/sst_pkg.sv
package sst_pkg;
  typedef enum logic {ST_IDLE = 1'b0, ST_SHIFT = 1'b1} sst_state_t;
  localparam int ERR_W = 3;
endpackage

// File: rtl/sst_clkgen.sv
module sst_clkgen #(
  parameter int DIV_W  = 8,
  parameter int SYNC_N = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             ext_sel,
  input  logic             ext_sck,
  input  logic [DIV_W-1:0] div_n,
  output logic             sck_q,
  output logic             fall_ev,
  output logic             rise_ev
);
  logic [SYNC_N:0]    sy;
  logic [DIV_W-1:0]   cnt;
  logic               tc;
  logic               ext_fall;
  logic               ext_rise;

  // synchronise the external clock, one extra stage for edge detection
  always_ff @(posedge clk) begin
    if (rst) sy <= '1;
    else     sy <= {sy[SYNC_N-1:0], ext_sck};
  end

  assign ext_fall = sy[SYNC_N] & ~sy[SYNC_N-1];
  assign ext_rise = ~sy[SYNC_N] & sy[SYNC_N-1];
  assign tc       = run && (cnt == div_n);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt   <= '0;
    end else if (tc) begin
      cnt   <= '0;
    end else begin
      cnt   <= cnt + 1'b1;
    end
  end

  // half-period phase; parked high when idle or clocked externally
  always_ff @(posedge clk) begin
    if (rst || !run || ext_sel) sck_q <= 1'b1;
    else if (tc)                sck_q <= ~sck_q;
  end

  assign fall_ev = ext_sel ? ext_fall : (tc &&  sck_q);
  assign rise_ev = ext_sel ? ext_rise : (tc && !sck_q);
endmodule

// File: rtl/sst_shifter.sv
module sst_shifter
  import sst_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ERR_W-1:0]  rx_err,
  input  logic              tie_en,
  input  logic              teie_en,
  input  logic              fall_ev,
  input  logic              rise_ev,
  output logic              run,
  output logic              txd_q,
  output logic              empty_q,
  output logic              tend_q,
  output logic              txi_q,
  output logic              tei_q
);
  localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  sst_state_t        st;
  logic [DATA_W-1:0] hold;
  logic [DATA_W-1:0] shreg;
  logic [CNT_W-1:0]  bitcnt;
  logic              go;
  logic              msb_end;
  logic              load;

  assign go      = !empty_q && (rx_err == '0);
  assign msb_end = (st == ST_SHIFT) && rise_ev && !fall_ev && (bitcnt == LAST);
  assign load    = go && ((st == ST_IDLE) || msb_end);
  assign run     = (st == ST_SHIFT);

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      hold    <= '0;
      shreg   <= '0;
      bitcnt  <= '0;
      txd_q   <= 1'b1;
      empty_q <= 1'b1;
      tend_q  <= 1'b1;
      txi_q   <= 1'b0;
      tei_q   <= 1'b0;
    end else begin
      txi_q <= 1'b0;
      tei_q <= 1'b0;
      if (wr_en) hold <= wr_data;

      if (wr_en)     empty_q <= 1'b0;
      else if (load) empty_q <= 1'b1;

      if (load) begin
        shreg  <= hold;
        bitcnt <= '0;
        tend_q <= 1'b0;
        txi_q  <= tie_en;
        st     <= ST_SHIFT;
      end else if (msb_end) begin
        tend_q <= 1'b1;
        tei_q  <= teie_en;
        st     <= ST_IDLE;
      end else if (st == ST_SHIFT) begin
        if (fall_ev) begin
          txd_q <= shreg[0];
          shreg <= {1'b0, shreg[DATA_W-1:1]};
        end else if (rise_ev) begin
          bitcnt <= bitcnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sync_ser_tx.sv
module sync_ser_tx
  import sst_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [DIV_W-1:0]  div_n,
  input  logic              ext_sel,
  input  logic              ext_sck,
  input  logic              tie_en,
  input  logic              teie_en,
  input  logic [ERR_W-1:0]  rx_err,
  output logic              sck_o,
  output logic              txd_o,
  output logic              empty_o,
  output logic              tend_o,
  output logic              txi_o,
  output logic              tei_o
);
  logic run;
  logic fall_ev;
  logic rise_ev;

  sst_clkgen #(.DIV_W(DIV_W), .SYNC_N(SYNC_N)) u_clk (
    .clk     (clk),
    .rst     (rst),
    .run     (run),
    .ext_sel (ext_sel),
    .ext_sck (ext_sck),
    .div_n   (div_n),
    .sck_q   (sck_o),
    .fall_ev (fall_ev),
    .rise_ev (rise_ev)
  );

  sst_shifter #(.DATA_W(DATA_W)) u_shf (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rx_err  (rx_err),
    .tie_en  (tie_en),
    .teie_en (teie_en),
    .fall_ev (fall_ev),
    .rise_ev (rise_ev),
    .run     (run),
    .txd_q   (txd_o),
    .empty_q (empty_o),
    .tend_q  (tend_o),
    .txi_q   (txi_o),
    .tei_q   (tei_o)
  );
endmodule

// File: rtl/sst_chk.sv
module sst_chk
  import sst_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             ext_sel,
  input logic             tie_en,
  input logic             teie_en,
  input logic [ERR_W-1:0] rx_err,
  input logic             sck_o,
  input logic             txd_o,
  input logic             empty_o,
  input logic             tend_o,
  input logic             txi_o,
  input logic             tei_o
);
  // R7
  idle_clk_high_chk: assert property (@(posedge clk) disable iff (rst)
    tend_o |-> sck_o);

  // R3
  low_clk_busy_chk: assert property (@(posedge clk) disable iff (rst)
    !sck_o |-> !tend_o);

  // R4
  txd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!ext_sel && $past(!ext_sel) && sck_o && $past(sck_o)) |-> (txd_o == $past(txd_o)));

  // R3
  txi_single_chk: assert property (@(posedge clk) disable iff (rst)
    txi_o |=> !txi_o);

  // R10
  txi_gate_chk: assert property (@(posedge clk) disable iff (rst)
    txi_o |-> $past(tie_en));

  // R10
  tei_gate_chk: assert property (@(posedge clk) disable iff (rst)
    tei_o |-> $past(teie_en));

  // R7
  tei_on_end_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(tend_o) && $past(teie_en)) |-> tei_o);

  // R8
  no_load_on_err_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(empty_o) |-> ($past(rx_err) == '0));

  // R9
  ext_clk_parked_chk: assert property (@(posedge clk) disable iff (rst)
    (ext_sel && $past(ext_sel)) |-> sck_o);
endmodule

bind sync_ser_tx sst_chk u_sst_chk (
  .clk     (clk),
  .rst     (rst),
  .ext_sel (ext_sel),
  .tie_en  (tie_en),
  .teie_en (teie_en),
  .rx_err  (rx_err),
  .sck_o   (sck_o),
  .txd_o   (txd_o),
  .empty_o (empty_o),
  .tend_o  (tend_o),
  .txi_o   (txi_o),
  .tei_o   (tei_o)
);

// File: tb/sync_ser_tx_bench.sv
`timescale 1ns/1ps
module sync_ser_tx_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] div_n = '0;
  logic       ext_sel = 1'b0;
  logic       ext_sck = 1'b1;
  logic       tie_en = 1'b1;
  logic       teie_en = 1'b1;
  logic [2:0] rx_err = '0;
  logic sck_o, txd_o, empty_o, tend_o, txi_o, tei_o;

  int nchk = 0;
  int nbad = 0;
  int cyc = 0;
  int txi_n = 0;
  int tei_n = 0;
  int ft [16];
  int rt [16];
  logic [15:0] got;

  // {data, divider}
  localparam logic [15:0] VEC [6] = '{
    {8'hA5, 8'd0}, {8'h3C, 8'd1}, {8'h01, 8'd2},
    {8'h80, 8'd3}, {8'hFF, 8'd1}, {8'h5A, 8'd4}
  };

  sync_ser_tx u_sync_ser_tx (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .div_n(div_n),
    .ext_sel(ext_sel), .ext_sck(ext_sck), .tie_en(tie_en), .teie_en(teie_en),
    .rx_err(rx_err), .sck_o(sck_o), .txd_o(txd_o), .empty_o(empty_o),
    .tend_o(tend_o), .txi_o(txi_o), .tei_o(tei_o)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) begin
    if (!rst && txi_o) txi_n <= txi_n + 1;
    if (!rst && tei_o) tei_n <= tei_n + 1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic wait_empty();
    for (int i = 0; i < 100 && !empty_o; i++) @(negedge clk);
  endtask

  task automatic run_frames(input int nf);
    int nr = 0;
    int nfa = 0;
    int guard = 0;
    logic prev;
    prev = sck_o;
    got = '0;
    while (nr < nf * 8 && guard < 20000) begin
      @(negedge clk);
      guard++;
      if (prev && !sck_o) begin
        if (nfa < 16) ft[nfa] = cyc;
        nfa++;
      end
      if (!prev && sck_o) begin
        got[nr] = txd_o;
        rt[nr] = cyc;
        nr++;
      end
      prev = sck_o;
    end
    if (guard >= 20000) chk("capture timeout", 32'(nr), 32'(nf * 8));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end

  initial begin
    int t0, e0;
    logic hi;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state: {sck,txd,empty,tend,txi,tei}
    chk("R1 reset outputs", {26'd0, sck_o, txd_o, empty_o, tend_o, txi_o, tei_o}, 32'b111100);

    // table walk: R2 R3 R4 R5 R7
    foreach (VEC[k]) begin
      div_n = VEC[k][7:0];
      t0 = txi_n; e0 = tei_n;
      fork
        run_frames(1);
        wr(VEC[k][15:8]);
      join
      repeat (2) @(negedge clk);
      chk("R4 frame bits", {24'd0, got[7:0]}, {24'd0, VEC[k][15:8]});
      chk("R5 bit period", 32'(ft[1] - ft[0]), 32'(2 * (int'(VEC[k][7:0]) + 1)));
      chk("R7 end levels {tend,sck,txd}", {29'd0, tend_o, sck_o, txd_o}, {29'd0, 1'b1, 1'b1, VEC[k][15]});
      chk("R3 txi pulse count", 32'(txi_n - t0), 32'd1);
      chk("R7 tei pulse count", 32'(tei_n - e0), 32'd1);
    end

    // R6 back-to-back frames
    div_n = 8'd2;
    t0 = txi_n; e0 = tei_n;
    fork
      run_frames(2);
      begin
        wr(8'h4B);
        wait_empty();
        chk("R3 load clears tend", {31'd0, tend_o}, 32'd0);
        wr(8'h72);
        chk("R2 write clears empty", {31'd0, empty_o}, 32'd0);
      end
    join
    repeat (2) @(negedge clk);
    chk("R6 two frames data", {16'd0, got}, {16'd0, 8'h72, 8'h4B});
    chk("R6 gap bit7 rise to next bit0 fall", 32'(ft[8] - rt[7]), 32'd3);
    chk("R6 txi twice tei once", 32'((txi_n - t0) * 16 + (tei_n - e0)), 32'h21);

    // R8 error raised mid-frame blocks continuation
    div_n = 8'd1;
    fork
      run_frames(1);
      begin
        wr(8'h11);
        wait_empty();
        wr(8'h9E);
        rx_err = 3'b001;
      end
    join
    repeat (4) @(negedge clk);
    chk("R8 stop on error {tend,empty}", {30'd0, tend_o, empty_o}, 32'b10);
    fork
      run_frames(1);
      begin @(negedge clk); rx_err = 3'b000; end
    join
    chk("R8 pending byte sent after release", {24'd0, got[7:0]}, 32'h9E);

    // R8 error before start
    repeat (4) @(negedge clk);
    rx_err = 3'b100;
    wr(8'h2D);
    hi = 1'b1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      hi &= sck_o;
    end
    chk("R8 no start {sck_high,empty,tend}", {29'd0, hi, empty_o, tend_o}, 32'b101);
    fork
      run_frames(1);
      begin @(negedge clk); rx_err = 3'b000; end
    join
    chk("R8 sent after clear", {24'd0, got[7:0]}, 32'h2D);

    // R10 interrupt enables off
    repeat (4) @(negedge clk);
    tie_en = 1'b0; teie_en = 1'b0;
    t0 = txi_n; e0 = tei_n;
    fork
      run_frames(1);
      wr(8'h33);
    join
    repeat (3) @(negedge clk);
    chk("R10 no irq pulses", 32'((txi_n - t0) + (tei_n - e0)), 32'd0);
    chk("R10 flag still set", {31'd0, tend_o}, 32'd1);
    tie_en = 1'b1; teie_en = 1'b1;

    // R9 external clock mode
    ext_sel = 1'b1; ext_sck = 1'b1;
    repeat (4) @(negedge clk);
    wr(8'h6D);
    wait_empty();
    repeat (2) @(negedge clk);
    hi = 1'b1;
    got = '0;
    for (int b = 0; b < 8; b++) begin
      ext_sck = 1'b0;
      repeat (6) @(negedge clk);
      got[b] = txd_o;
      hi &= sck_o;
      ext_sck = 1'b1;
      repeat (6) @(negedge clk);
      hi &= sck_o;
    end
    chk("R9 external clocked bits", {24'd0, got[7:0]}, 32'h6D);
    chk("R9 sck_o parked high", {31'd0, hi}, 32'd1);
    chk("R7 end in external mode {tend,txd}", {30'd0, tend_o, txd_o}, 32'b10);
    ext_sel = 1'b0;

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end
endmodule